// File: doc/BRIEF.md
# Frame Test Pattern Generator

This block is a self-contained stimulus source for a block-interleaved Reed-Solomon encoder. It produces a serial message bit stream together with a frame strobe. The strobe is high while message bytes are sent and low for the span in which the encoder would append its parity. The frame then repeats without end. A 3-bit pattern select picks one of four fixed byte patterns. A 2-bit depth select sets the interleave depth I, which fixes both the message length and the parity length.

The generator advances one bit per cycle in which the bit-rate enable is high. Its outputs can drive the encoder's message and strobe inputs directly. A ready flag tells downstream logic that the stream has completed a full warm-up frame and can now be trusted.

Top module: `frame_test_gen`

## Requirements
- R1: While rst_n is low, frame_strobe, msg_bit and ready are 0. After reset they stay 0 until the first cycle with bit_en high. At that edge frame_strobe rises and bit 7 of message byte 0 appears on msg_bit.
- R2: depth_sel is decoded as 2'b00 to I=5, 2'b01 to I=4, 2'b10 to I=1 and 2'b11 to I=5. frame_strobe stays high for exactly 223*I bytes (8*223*I enabled cycles).
- R3: After the message bytes, frame_strobe is low for exactly 32*I bytes, and msg_bit is 0 throughout. frame_strobe then rises to begin the next frame.
- R4: Bytes are shifted out MSB first, one bit per enabled cycle. In cycles with bit_en low, frame_strobe and msg_bit do not change.
- R5: pat_sel 3'b001 sends the byte sequence 1, 2, ..., I repeatedly for 223 rounds. At I=1 every byte is 0x01.
- R6: pat_sel 3'b010 sends zero bytes, except the last message byte, which is 0x7B.
- R7: pat_sel 3'b011 sends zero bytes followed by a tail of I bytes. The tail is the first I entries of the list 0x7B, 0xAF, 0x99, 0xFA, 0xB7.
- R8: pat_sel 3'b100 sends zero bytes, then I bytes of 0x7B, then I bytes of 0x47. At I=1 it instead sends 222 zero bytes followed by a single 0x7B.
- R9: pat_sel codes 3'b000, 3'b101, 3'b110 and 3'b111 send all-zero message bytes, and the strobe keeps its normal timing.
- R10: ready is 0 through the whole first frame after reset. It rises on the same edge as the second rise of frame_strobe and stays high until the next reset.
- R11: pat_sel and depth_sel are sampled only on the edge where frame_strobe rises. A change during a frame takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable; one output bit per high cycle |
| pat_sel | input | 3 | Test pattern select |
| depth_sel | input | 2 | Interleave depth select |
| msg_bit | output | 1 | Serial message bit, MSB first |
| frame_strobe | output | 1 | High during message bytes, low during parity time |
| ready | output | 1 | Stream valid after the warm-up frame |

## Verification
The stream is compared byte by byte against a model written from the requirements. Every defined pattern runs at each depth where its tail differs: the counting pattern at I=1 and I=5 shows the lane wrap, the tail pattern at I=4 and I=5 shows the tail length, and the paired pattern at I=1 and I=5 separates the single-byte special case from the general layout. Undefined codes at I=1 show that the strobe timing is independent of the pattern. Selects changed mid-frame show that frames are latched at the boundary, and a stalled enable shows that bits advance only on enabled cycles.

// File: rtl/ftpg_pkg.sv
package ftpg_pkg;

    parameter int unsigned MAX_DEPTH = 5;
    localparam int unsigned DEPTH_W  = $clog2(MAX_DEPTH + 1);
    localparam int unsigned LANE_W   = $clog2(MAX_DEPTH);

    // pattern select codes
    localparam logic [2:0] PAT_COUNT = 3'b001;
    localparam logic [2:0] PAT_LAST  = 3'b010;
    localparam logic [2:0] PAT_TAIL  = 3'b011;
    localparam logic [2:0] PAT_PAIR  = 3'b100;

    localparam logic [7:0] BYTE_MARK = 8'h7B;
    localparam logic [7:0] BYTE_PAIR = 8'h47;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DATA  = 2'd1,
        PH_CHECK = 2'd2
    } phase_e;

    typedef struct packed {
        logic [2:0]         pat;
        logic [DEPTH_W-1:0] depth;
    } cfg_t;

    function automatic logic [DEPTH_W-1:0] decode_depth(input logic [1:0] sel);
        case (sel)
            2'b01:   return DEPTH_W'(4);
            2'b10:   return DEPTH_W'(1);
            default: return DEPTH_W'(5);
        endcase
    endfunction

    function automatic logic [7:0] tail_byte(input logic [LANE_W-1:0] lane);
        case (lane)
            LANE_W'(0): return 8'h7B;
            LANE_W'(1): return 8'hAF;
            LANE_W'(2): return 8'h99;
            LANE_W'(3): return 8'hFA;
            default:    return 8'hB7;
        endcase
    endfunction

endpackage

// File: rtl/ftpg_frame_timer.sv
module ftpg_frame_timer
    import ftpg_pkg::*;
#(
    parameter int unsigned DATA_BYTES  = 223,
    parameter int unsigned CHECK_BYTES = 32,
    parameter int unsigned CNT_W       = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [2:0]        pat_sel,
    input  logic [1:0]        depth_sel,
    output phase_e            phase,
    output logic [2:0]        bit_idx,
    output logic [CNT_W-1:0]  byte_idx,
    output logic [LANE_W-1:0] lane,
    output cfg_t              cfg,
    output logic              frame_start
);

    typedef struct packed {
        phase_e             phase;
        logic [2:0]         bit_idx;
        logic [CNT_W-1:0]   byte_idx;
        logic [LANE_W-1:0]  lane;
        cfg_t               cfg;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic start_d;
    logic [CNT_W-1:0]  data_last;
    logic [CNT_W-1:0]  check_last;
    logic [LANE_W-1:0] lane_last;

    always_comb begin
        tmr_d      = tmr_q;
        start_d    = 1'b0;
        data_last  = CNT_W'(DATA_BYTES * tmr_q.cfg.depth - 1);
        check_last = CNT_W'(CHECK_BYTES * tmr_q.cfg.depth - 1);
        lane_last  = LANE_W'(tmr_q.cfg.depth - 1'b1);

        if (bit_en) begin
            case (tmr_q.phase)
                PH_IDLE: start_d = 1'b1;
                PH_DATA: begin
                    tmr_d.bit_idx = tmr_q.bit_idx + 3'd1;
                    if (tmr_q.bit_idx == 3'd7) begin
                        if (tmr_q.byte_idx == data_last) begin
                            tmr_d.phase    = PH_CHECK;
                            tmr_d.byte_idx = '0;
                            tmr_d.lane     = '0;
                        end else begin
                            tmr_d.byte_idx = tmr_q.byte_idx + 1'b1;
                            tmr_d.lane     = (tmr_q.lane == lane_last) ? '0
                                                                       : tmr_q.lane + 1'b1;
                        end
                    end
                end
                PH_CHECK: begin
                    tmr_d.bit_idx = tmr_q.bit_idx + 3'd1;
                    if (tmr_q.bit_idx == 3'd7) begin
                        if (tmr_q.byte_idx == check_last) begin
                            start_d = 1'b1;
                        end else begin
                            tmr_d.byte_idx = tmr_q.byte_idx + 1'b1;
                        end
                    end
                end
                default: tmr_d.phase = PH_IDLE;
            endcase
        end

        // frame boundary: restart counters and capture the selects
        if (start_d) begin
            tmr_d.phase     = PH_DATA;
            tmr_d.bit_idx   = 3'd0;
            tmr_d.byte_idx  = '0;
            tmr_d.lane      = '0;
            tmr_d.cfg.pat   = pat_sel;
            tmr_d.cfg.depth = decode_depth(depth_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q           <= '0;
            tmr_q.phase     <= PH_IDLE;
            tmr_q.cfg.depth <= DEPTH_W'(1);
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign phase       = tmr_q.phase;
    assign bit_idx     = tmr_q.bit_idx;
    assign byte_idx    = tmr_q.byte_idx;
    assign lane        = tmr_q.lane;
    assign cfg         = tmr_q.cfg;
    assign frame_start = start_d;

endmodule

// File: rtl/ftpg_byte_src.sv
module ftpg_byte_src
    import ftpg_pkg::*;
#(
    parameter int unsigned DATA_BYTES = 223,
    parameter int unsigned CNT_W      = 11
) (
    input  cfg_t              cfg,
    input  logic [CNT_W-1:0]  byte_idx,
    input  logic [LANE_W-1:0] lane,
    output logic [7:0]        byte_val
);

    int total;
    int idx;
    int dep;
    logic is_last;
    logic in_tail;
    logic in_pair;

    always_comb begin
        dep      = int'(cfg.depth);
        total    = int'(DATA_BYTES) * dep;
        idx      = int'(byte_idx);
        is_last  = (idx == total - 1);
        in_tail  = (idx >= total - dep);
        in_pair  = (idx >= total - 2 * dep);
        byte_val = 8'h00;

        case (cfg.pat)
            PAT_COUNT: byte_val = 8'(lane) + 8'd1;
            PAT_LAST:  byte_val = is_last ? BYTE_MARK : 8'h00;
            PAT_TAIL:  byte_val = in_tail ? tail_byte(lane) : 8'h00;
            PAT_PAIR: begin
                if (dep == 1) begin
                    byte_val = is_last ? BYTE_MARK : 8'h00;
                end else if (in_tail) begin
                    byte_val = BYTE_PAIR;
                end else if (in_pair) begin
                    byte_val = BYTE_MARK;
                end
            end
            default:   byte_val = 8'h00;
        endcase
    end

endmodule

// File: rtl/ftpg_ready_trk.sv
module ftpg_ready_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    output logic ready
);

    typedef struct packed {
        logic seen;
        logic ready;
    } rdy_t;

    rdy_t rdy_d, rdy_q;

    always_comb begin
        rdy_d = rdy_q;
        if (frame_start) begin
            rdy_d.seen = 1'b1;
            if (rdy_q.seen) begin
                rdy_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= '0;
        end else begin
            rdy_q <= rdy_d;
        end
    end

    assign ready = rdy_q.ready;

endmodule

// File: rtl/frame_test_gen.sv
module frame_test_gen
    import ftpg_pkg::*;
#(
    parameter int unsigned DATA_BYTES  = 223,
    parameter int unsigned CHECK_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic [2:0] pat_sel,
    input  logic [1:0] depth_sel,
    output logic       msg_bit,
    output logic       frame_strobe,
    output logic       ready
);

    localparam int unsigned CNT_W = $clog2(DATA_BYTES * MAX_DEPTH);

    phase_e            phase;
    logic [2:0]        bit_idx;
    logic [CNT_W-1:0]  byte_idx;
    logic [LANE_W-1:0] lane;
    cfg_t              cfg;
    logic              frame_start;
    logic [7:0]        byte_val;

    ftpg_frame_timer #(
        .DATA_BYTES (DATA_BYTES),
        .CHECK_BYTES(CHECK_BYTES),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .pat_sel    (pat_sel),
        .depth_sel  (depth_sel),
        .phase      (phase),
        .bit_idx    (bit_idx),
        .byte_idx   (byte_idx),
        .lane       (lane),
        .cfg        (cfg),
        .frame_start(frame_start)
    );

    ftpg_byte_src #(
        .DATA_BYTES(DATA_BYTES),
        .CNT_W     (CNT_W)
    ) u_src (
        .cfg     (cfg),
        .byte_idx(byte_idx),
        .lane    (lane),
        .byte_val(byte_val)
    );

    ftpg_ready_trk u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .ready      (ready)
    );

    // outputs are decoded from registered state only
    always_comb begin
        frame_strobe = (phase == PH_DATA);
        msg_bit      = frame_strobe ? byte_val[3'd7 - bit_idx] : 1'b0;
    end

endmodule

// File: rtl/frame_test_gen_chk.sv
module frame_test_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic frame_strobe,
    input logic msg_bit,
    input logic ready
);

    // R3
    msg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |-> !msg_bit);

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(frame_strobe) && $stable(msg_bit)));

    // R1
    strobe_rise_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_strobe) |-> $past(bit_en));

    // R10
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R10
    ready_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $rose(frame_strobe));

endmodule

bind frame_test_gen frame_test_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .frame_strobe(frame_strobe),
    .msg_bit     (msg_bit),
    .ready       (ready)
);

// File: tb/sim_frame_test_gen.sv
module sim_frame_test_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic [2:0] pat_sel;
    logic [1:0] depth_sel;
    logic       msg_bit;
    logic       frame_strobe;
    logic       ready;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    frame_test_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .pat_sel     (pat_sel),
        .depth_sel   (depth_sel),
        .msg_bit     (msg_bit),
        .frame_strobe(frame_strobe),
        .ready       (ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int depth_of(input logic [1:0] s);
        case (s)
            2'b01:   return 4;
            2'b10:   return 1;
            default: return 5;
        endcase
    endfunction

    function automatic logic [7:0] tail_exp(input int k);
        case (k)
            0:       return 8'h7B;
            1:       return 8'hAF;
            2:       return 8'h99;
            3:       return 8'hFA;
            default: return 8'hB7;
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(input logic [2:0] pat, input int dep, input int idx);
        int n;
        n = 223 * dep;
        case (pat)
            3'b001: return 8'((idx % dep) + 1);
            3'b010: return (idx == n - 1) ? 8'h7B : 8'h00;
            3'b011: return (idx >= n - dep) ? tail_exp(idx - (n - dep)) : 8'h00;
            3'b100: begin
                if (dep == 1)           return (idx == n - 1) ? 8'h7B : 8'h00;
                if (idx >= n - dep)     return 8'h47;
                if (idx >= n - 2 * dep) return 8'h7B;
                return 8'h00;
            end
            default: return 8'h00;
        endcase
    endfunction

    task automatic advance();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Entered at the negedge after frame_strobe rose; leaves at the next such point.
    task automatic run_frame(input string req, input logic [2:0] pat, input logic [1:0] dsel,
                             input logic exp_ready, input logic [2:0] nxt_pat,
                             input logic [1:0] nxt_dsel, input bit mid_change, input bit gap);
        int dep;
        int nd;
        int nc;
        int bad;
        int first_idx;
        int quiet_bad;
        logic [7:0] cur;
        logic [7:0] first_act;
        logic [7:0] first_exp;
        logic strobe_ok;
        logic s0;
        logic m0;
        dep       = depth_of(dsel);
        nd        = 223 * dep;
        nc        = 32 * dep;
        bad       = 0;
        first_idx = -1;
        quiet_bad = 0;
        cur       = 8'h00;
        first_act = 8'h00;
        first_exp = 8'h00;
        strobe_ok = 1'b1;

        check(ready === exp_ready, "R10", "ready at frame start", int'(ready), int'(exp_ready));

        for (int i = 0; i < nd * 8; i++) begin
            if (frame_strobe !== 1'b1) strobe_ok = 1'b0;
            cur = {cur[6:0], msg_bit};
            if (i % 8 == 7) begin
                if (cur !== exp_byte(pat, dep, i / 8)) begin
                    bad++;
                    if (first_idx < 0) begin
                        first_idx = i / 8;
                        first_act = cur;
                        first_exp = exp_byte(pat, dep, i / 8);
                    end
                end
            end
            // R11: selects change mid-frame, must not affect this frame
            if (mid_change && i == nd * 4) begin
                pat_sel   = nxt_pat;
                depth_sel = nxt_dsel;
            end
            // R4: stall the enable and watch outputs hold
            if (gap && i == 21) begin
                s0     = frame_strobe;
                m0     = msg_bit;
                bit_en = 1'b0;
                for (int k = 0; k < 5; k++) begin
                    @(negedge clk);
                    check(frame_strobe === s0 && msg_bit === m0, "R4",
                          "outputs hold with bit_en low", int'({frame_strobe, msg_bit}),
                          int'({s0, m0}));
                end
                bit_en = 1'b1;
            end
            advance();
        end

        check(strobe_ok === 1'b1, "R2", "strobe high through message bytes", 0, 1);
        check(bad == 0, req, $sformatf("message byte %0d", first_idx),
              int'(first_act), int'(first_exp));
        check(frame_strobe === 1'b0, "R2", "strobe low after 223*I bytes",
              int'(frame_strobe), 0);

        if (!mid_change) begin
            pat_sel   = nxt_pat;
            depth_sel = nxt_dsel;
        end

        for (int j = 0; j < nc * 8; j++) begin
            if (frame_strobe !== 1'b0 || msg_bit !== 1'b0 || ready !== exp_ready) quiet_bad++;
            advance();
        end
        check(quiet_bad == 0, "R3", "parity span strobe/msg low", quiet_bad, 0);
        check(frame_strobe === 1'b1, "R3", "strobe rises after 32*I bytes",
              int'(frame_strobe), 1);
    endtask

    task automatic reset_and_start();
        rst_n     = 1'b0;
        bit_en    = 1'b0;
        pat_sel   = 3'b001;
        depth_sel = 2'b10;
        repeat (3) @(negedge clk);
        check(frame_strobe === 1'b0 && msg_bit === 1'b0 && ready === 1'b0, "R1",
              "outputs in reset", int'({frame_strobe, msg_bit, ready}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(frame_strobe === 1'b0 && ready === 1'b0, "R1", "idle before first enable",
              int'({frame_strobe, ready}), 0);
        bit_en = 1'b1;
        @(negedge clk);
        check(frame_strobe === 1'b1, "R1", "strobe rises on first enable",
              int'(frame_strobe), 1);
        check(msg_bit === 1'b0, "R1", "first bit is MSB of 0x01", int'(msg_bit), 0);
    endtask

    task automatic mid_reset();
        repeat (30) advance();
        rst_n = 1'b0;
        @(negedge clk);
        check(frame_strobe === 1'b0 && msg_bit === 1'b0 && ready === 1'b0, "R1",
              "outputs cleared by mid-frame reset", int'({frame_strobe, msg_bit, ready}), 0);
        rst_n = 1'b1;
        advance();
        check(frame_strobe === 1'b1 && ready === 1'b0, "R10",
              "ready low in first frame after reset", int'({frame_strobe, ready}), 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        reset_and_start();
        run_frame("R5",     3'b001, 2'b10, 1'b0, 3'b100, 2'b10, 1'b0, 1'b0);
        run_frame("R8 R11", 3'b100, 2'b10, 1'b1, 3'b011, 2'b01, 1'b1, 1'b0);
        run_frame("R7",     3'b011, 2'b01, 1'b1, 3'b001, 2'b00, 1'b0, 1'b1);
        run_frame("R5",     3'b001, 2'b00, 1'b1, 3'b100, 2'b11, 1'b0, 1'b0);
        run_frame("R8",     3'b100, 2'b11, 1'b1, 3'b010, 2'b01, 1'b0, 1'b0);
        run_frame("R6 R11", 3'b010, 2'b01, 1'b1, 3'b011, 2'b00, 1'b1, 1'b0);
        run_frame("R7",     3'b011, 2'b00, 1'b1, 3'b000, 2'b10, 1'b0, 1'b0);
        run_frame("R9",     3'b000, 2'b10, 1'b1, 3'b111, 2'b10, 1'b0, 1'b0);
        run_frame("R9",     3'b111, 2'b10, 1'b1, 3'b001, 2'b10, 1'b0, 1'b0);
        mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule